// File: doc/BRIEF.md
# Training-Pattern Sampling Phase Selector

This block lines up one serial receive lane with the shared clock. The lane has already been sampled by several strobes that are evenly spaced across one bit period. Each bit period, the block receives those samples as one parallel vector. While a known training word repeats on the line, the block treats each strobe's sample stream as a candidate bit stream. A candidate becomes valid once it has shown the training word, at any rotation, without a break for a programmable number of word lengths. In the first bit period that any strobe is valid, the block takes the strobe at the middle of the longest contiguous group of valid strobes. It then freezes that choice and raises its locked flag. From then on it delivers one retimed bit per bit period from the chosen strobe.

Each lane uses its own instance, so skew between lanes up to half a bit period is absorbed lane by lane. A calibration request clears the lock and any error and starts a new search. If no strobe becomes valid within a programmable number of word periods, the search stops and an error flag is raised instead of the locked flag. Word framing is left to logic downstream.

Top module: `phase_select_rx`

## Requirements
- R1: After reset, `locked` and `calError` are 0, `selPhase` is NPHASE/2 (2 with five strobes) and `retimedBit` is 0. The search starts at the first clock after reset.
- R2: Each strobe keeps a window of its last PAT_LEN samples, with the newest sample in the LSB. The window counts as a match when it equals some rotation of PATTERN (default 8'b00010111). A match is only counted once PAT_LEN samples have been taken since the search began. A strobe is valid once its window has matched in `max(reqReps,1) * PAT_LEN` consecutive bit periods, so `reqReps` = 0 behaves as 1.
- R3: The lock decision is taken in the first search bit period in which any strobe is valid, and `locked` is high from the next cycle. Counting from the first search bit period, `locked` is first seen after `PAT_LEN + max(reqReps,1)*PAT_LEN + 1` bit periods.
- R4: The chosen strobe is `start + (len-1)/2` of the longest contiguous run of valid strobes, indexed from 0. When two runs have the same length, the lower-indexed run wins.
- R5: Once `locked` is high, `selPhase` and `locked` hold regardless of the samples until `calReq` is asserted.
- R6: A cycle with `calReq` high clears `locked`, `calError`, every window and every count. The search restarts on the first cycle with `calReq` low. `selPhase` keeps its previous value until the next lock.
- R7: If no strobe is valid by the end of `timeoutPeriods` word periods of search (minimum one word period), `calError` rises after exactly `8*timeoutPeriods` search bit periods for PAT_LEN = 8. `locked` stays low and the search halts until `calReq`.
- R8: In every cycle, `retimedBit` equals `phaseSamples[selPhase]` from the previous bit period.
- R9: Strobes are qualified independently. A single bad sample on one strobe resets only that strobe's count and does not delay another strobe's validity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-period clock |
| rstN | input | 1 | Asynchronous active-low reset |
| calReq | input | 1 | Clear lock and error and restart the search |
| phaseSamples | input | NPHASE | Line value captured at each strobe this bit period |
| reqReps | input | REPS_W | Training word repetitions needed for a strobe to be valid |
| timeoutPeriods | input | TO_W | Search limit in training word periods |
| retimedBit | output | 1 | Bit taken from the chosen strobe, one cycle late |
| selPhase | output | $clog2(NPHASE) | Index of the chosen strobe |
| locked | output | 1 | A strobe has been chosen and is frozen |
| calError | output | 1 | Search timed out without a valid strobe |

## Verification
The bench targets the exact lock cycle for several repetition counts, including zero. A design that qualifies one word period too early or too late, or that counts before the window is full, shows `locked` off by one or more cycles. Valid masks with an even-length run, a run at the top edge and two tied runs check the centre rule. An off-by-one centre or a wrong tie preference selects a neighbouring strobe. A one-sample glitch on the edge strobe must drop only that strobe from the run. Noise after lock, timeout counting and clearing by request catch a selection that drifts, an error raised a word early, or a lock that survives a new request.

// File: rtl/phsel_pkg.sv
package phsel_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_LOCKED = 2'd1,
    ST_FAILED = 2'd2
  } calState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;   // wipe windows and run counts
    logic advance;    // shift in one sample per strobe
    logic lockNow;    // capture the picked strobe index
  } ctlStrobe_t;
endpackage

// File: rtl/phsel_datapath.sv
module phsel_datapath
  import phsel_pkg::*;
#(
  parameter int NPHASE = 5,
  parameter int PAT_LEN = 8,
  parameter logic [PAT_LEN-1:0] PATTERN = 8'b00010111,
  parameter int REPS_W = 4,
  parameter int SELW = 3,
  parameter int RUN_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NPHASE-1:0] phaseSamples,
  input  logic [REPS_W-1:0] reqReps,
  input  ctlStrobe_t        strobe,
  input  logic [SELW-1:0]   lockPick,
  output logic [NPHASE-1:0] validMask,
  output logic [SELW-1:0]   selPhase,
  output logic              retimedBit
);
  localparam int FILL_W = $clog2(PAT_LEN + 1);

  logic [FILL_W-1:0] fillCnt;
  logic [REPS_W-1:0] repsEff;
  logic [RUN_W-1:0]  runTarget;
  logic              windowFull;

  assign repsEff    = (reqReps == '0) ? REPS_W'(1) : reqReps;
  assign runTarget  = RUN_W'(repsEff) * RUN_W'(PAT_LEN);
  assign windowFull = (fillCnt == FILL_W'(PAT_LEN));

  function automatic logic isRotation(input logic [PAT_LEN-1:0] win);
    logic [PAT_LEN-1:0] rot;
    logic hit;
    hit = 1'b0;
    for (int r = 0; r < PAT_LEN; r++) begin
      rot = (PATTERN << r) | (PATTERN >> (PAT_LEN - r));
      if (rot == win) hit = 1'b1;
    end
    return hit;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                fillCnt <= '0;
    else if (strobe.clearAll) fillCnt <= '0;
    else if (strobe.advance && !windowFull) fillCnt <= fillCnt + 1'b1;
  end

  for (genvar p = 0; p < NPHASE; p++) begin : g_lane
    logic [PAT_LEN-1:0] hist;
    logic [RUN_W-1:0]   runCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hist   <= '0;
        runCnt <= '0;
      end else if (strobe.clearAll) begin
        hist   <= '0;
        runCnt <= '0;
      end else if (strobe.advance) begin
        hist <= {hist[PAT_LEN-2:0], phaseSamples[p]};
        if (windowFull && isRotation(hist))
          runCnt <= (runCnt >= runTarget) ? runCnt : runCnt + 1'b1;
        else
          runCnt <= '0;
      end
    end

    assign validMask[p] = (runCnt >= runTarget);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selPhase   <= SELW'(NPHASE / 2);
      retimedBit <= 1'b0;
    end else begin
      retimedBit <= phaseSamples[selPhase];
      if (strobe.lockNow) selPhase <= lockPick;
    end
  end
endmodule

// File: rtl/phsel_control.sv
module phsel_control
  import phsel_pkg::*;
#(
  parameter int NPHASE = 5,
  parameter int PAT_LEN = 8,
  parameter int TO_W = 8,
  parameter int SELW = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              calReq,
  input  logic [TO_W-1:0]   timeoutPeriods,
  input  logic [NPHASE-1:0] validMask,
  output ctlStrobe_t        strobe,
  output logic [SELW-1:0]   lockPick,
  output logic              locked,
  output logic              calError
);
  localparam int BIT_W = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1;

  calState_t       state;
  logic [BIT_W-1:0] bitCnt;
  logic [TO_W-1:0]  periodCnt;
  logic             periodDone;
  logic             timeoutHit;
  logic             anyValid;

  function automatic logic [SELW-1:0] pickCentre(input logic [NPHASE-1:0] mask);
    int bestStart, bestLen, curStart, curLen;
    bestStart = 0; bestLen = 0; curStart = 0; curLen = 0;
    for (int i = 0; i < NPHASE; i++) begin
      if (mask[i]) begin
        if (curLen == 0) curStart = i;
        curLen++;
        if (curLen > bestLen) begin
          bestLen   = curLen;
          bestStart = curStart;
        end
      end else begin
        curLen = 0;
      end
    end
    if (bestLen == 0) bestLen = 1;
    return SELW'(bestStart + (bestLen - 1) / 2);
  endfunction

  assign anyValid   = |validMask;
  assign periodDone = (bitCnt == BIT_W'(PAT_LEN - 1));
  assign timeoutHit = periodDone &&
                      ({1'b0, periodCnt} + 1'b1 >= {1'b0, timeoutPeriods});

  always_comb begin
    strobe.clearAll = calReq;
    strobe.advance  = (state == ST_SEARCH) && !calReq;
    strobe.lockNow  = strobe.advance && anyValid;
  end

  assign lockPick = pickCentre(validMask);
  assign locked   = (state == ST_LOCKED);
  assign calError = (state == ST_FAILED);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_SEARCH;
      bitCnt    <= '0;
      periodCnt <= '0;
    end else if (calReq) begin
      state     <= ST_SEARCH;
      bitCnt    <= '0;
      periodCnt <= '0;
    end else if (state == ST_SEARCH) begin
      if (anyValid)        state <= ST_LOCKED;
      else if (timeoutHit) state <= ST_FAILED;
      bitCnt <= periodDone ? '0 : bitCnt + 1'b1;
      if (periodDone) periodCnt <= periodCnt + 1'b1;
    end
  end
endmodule

// File: rtl/phase_select_rx.sv
module phase_select_rx
  import phsel_pkg::*;
#(
  parameter int NPHASE = 5,
  parameter int PAT_LEN = 8,
  parameter logic [PAT_LEN-1:0] PATTERN = 8'b00010111,
  parameter int REPS_W = 4,
  parameter int TO_W = 8,
  localparam int SELW = $clog2(NPHASE),
  localparam int RUN_W = $clog2(((1 << REPS_W) - 1) * PAT_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              calReq,
  input  logic [NPHASE-1:0] phaseSamples,
  input  logic [REPS_W-1:0] reqReps,
  input  logic [TO_W-1:0]   timeoutPeriods,
  output logic              retimedBit,
  output logic [SELW-1:0]   selPhase,
  output logic              locked,
  output logic              calError
);
  ctlStrobe_t        strobe;
  logic [SELW-1:0]   lockPick;
  logic [NPHASE-1:0] validMask;

  phsel_control #(
    .NPHASE(NPHASE), .PAT_LEN(PAT_LEN), .TO_W(TO_W), .SELW(SELW)
  ) i_control (
    .clk(clk), .rstN(rstN), .calReq(calReq), .timeoutPeriods(timeoutPeriods),
    .validMask(validMask), .strobe(strobe), .lockPick(lockPick),
    .locked(locked), .calError(calError)
  );

  phsel_datapath #(
    .NPHASE(NPHASE), .PAT_LEN(PAT_LEN), .PATTERN(PATTERN),
    .REPS_W(REPS_W), .SELW(SELW), .RUN_W(RUN_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .phaseSamples(phaseSamples), .reqReps(reqReps),
    .strobe(strobe), .lockPick(lockPick), .validMask(validMask),
    .selPhase(selPhase), .retimedBit(retimedBit)
  );
endmodule

// File: rtl/phsel_checker.sv
module phsel_checker #(
  parameter int NPHASE = 5,
  parameter int SELW = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              calReq,
  input logic [NPHASE-1:0] phaseSamples,
  input logic              retimedBit,
  input logic [SELW-1:0]   selPhase,
  input logic              locked,
  input logic              calError
);
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  AST_LOCK_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(locked && calError)); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    calError && !calReq |=> calError); // R7

  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    locked && !calReq |=> locked && $stable(selPhase)); // R5

  AST_REQ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    calReq |=> !locked && !calError); // R6

  AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    32'(selPhase) < NPHASE); // R4

  AST_RETIME_PATH: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> retimedBit == $past(phaseSamples[selPhase])); // R8
endmodule

bind phase_select_rx phsel_checker #(.NPHASE(NPHASE), .SELW(SELW)) i_phselChk (
  .clk(clk), .rstN(rstN), .calReq(calReq), .phaseSamples(phaseSamples),
  .retimedBit(retimedBit), .selPhase(selPhase), .locked(locked), .calError(calError)
);

// File: tb/test_phase_select_rx.sv
`timescale 1ns/1ps
module test_phase_select_rx;
  localparam logic [7:0] TRAIN = 8'b00010111;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       calReq = 1'b0;
  logic [4:0] phaseSamples = '0;
  logic [3:0] reqReps = 4'd4;
  logic [7:0] timeoutPeriods = 8'd200;
  logic       retimedBit;
  logic [2:0] selPhase;
  logic       locked;
  logic       calError;

  int errors = 0;
  int checks = 0;

  logic [4:0] goodMask = 5'b01110;
  logic [4:0] glitchMask = 5'b00000;
  int lineIdx = 0;
  bit compareOn = 0;

  always #4 clk = ~clk;

  phase_select_rx i_phase_select_rx (
    .clk(clk), .rstN(rstN), .calReq(calReq), .phaseSamples(phaseSamples),
    .reqReps(reqReps), .timeoutPeriods(timeoutPeriods), .retimedBit(retimedBit),
    .selPhase(selPhase), .locked(locked), .calError(calError)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mHist[5];
  int mRun[5];
  int mFill, mBit, mPeriod, mState, mSel, mRet;

  function automatic bit inTrain(input int w);
    int dbl = (int'(TRAIN) << 8) | int'(TRAIN);
    for (int r = 0; r < 8; r++) if (((dbl >> r) & 255) == w) return 1;
    return 0;
  endfunction

  function automatic int modelPick(input bit v[5]);
    int best = 0, bs = 0;
    for (int s = 0; s < 5; s++) begin
      int len = 0;
      while (s + len < 5 && v[s + len]) len++;
      if (len > best) begin best = len; bs = s; end
    end
    if (best == 0) best = 1;
    return bs + (best - 1) / 2;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mHist[p]) begin mHist[p] = 0; mRun[p] = 0; end
      mFill = 0; mBit = 0; mPeriod = 0; mState = 0; mSel = 2; mRet = 0;
    end else begin
      int thr;
      bit v[5];
      bit anyV;
      thr = (reqReps == 0 ? 1 : int'(reqReps)) * 8;
      anyV = 0;
      for (int p = 0; p < 5; p++) begin v[p] = mRun[p] >= thr; anyV |= v[p]; end
      mRet = phaseSamples[mSel];
      if (calReq) begin
        foreach (mHist[p]) begin mHist[p] = 0; mRun[p] = 0; end
        mFill = 0; mBit = 0; mPeriod = 0; mState = 0;
      end else if (mState == 0) begin
        if (anyV) begin mSel = modelPick(v); mState = 1; end
        else if (mBit == 7 && mPeriod + 1 >= int'(timeoutPeriods)) mState = 2;
        for (int p = 0; p < 5; p++) begin
          if (mFill == 8 && inTrain(mHist[p])) mRun[p] = (mRun[p] + 1 > thr) ? thr : mRun[p] + 1;
          else mRun[p] = 0;
          mHist[p] = ((mHist[p] << 1) | int'(phaseSamples[p])) & 255;
        end
        if (mFill < 8) mFill++;
        if (mBit == 7) begin mBit = 0; mPeriod++; end else mBit++;
      end
    end
  end

  always @(negedge clk) begin
    if (compareOn) begin
      chk("R3 locked vs model", int'(locked), int'(mState == 1));
      chk("R7 calError vs model", int'(calError), int'(mState == 2));
      chk("R4 selPhase vs model", int'(selPhase), mSel);
      chk("R8 retimedBit vs model", int'(retimedBit), mRet);
    end
  end

  // ---------------- line feeder ----------------
  initial begin
    forever begin
      @(negedge clk);
      begin
        logic lineBit;
        logic [4:0] s;
        lineBit = TRAIN[7 - (lineIdx % 8)];
        for (int p = 0; p < 5; p++)
          s[p] = goodMask[p] ? lineBit : logic'($urandom & 1);
        phaseSamples = s ^ glitchMask;
        lineIdx++;
      end
    end
  end

  task automatic calibrate(input int reps, output int cycles, input bit doGlitch);
    reqReps = reps[3:0];
    @(negedge clk); calReq = 1'b1;
    @(negedge clk); calReq = 1'b0;
    chk("R6 locked cleared by request", int'(locked), 0);
    chk("R6 calError cleared by request", int'(calError), 0);
    cycles = 0;
    while (!locked && !calError && cycles < 3000) begin
      @(negedge clk);
      cycles++;
      if (doGlitch && cycles == 20) glitchMask = 5'b10000;
      if (doGlitch && cycles == 21) glitchMask = 5'b00000;
    end
    glitchMask = 5'b00000;
  endtask

  initial begin
    #(8ns * 150000);
    errors++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int cyc;
    logic prevBit;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 locked in reset", int'(locked), 0);
    chk("R1 calError in reset", int'(calError), 0);
    chk("R1 selPhase in reset", int'(selPhase), 2);
    chk("R1 retimedBit in reset", int'(retimedBit), 0);
    rstN = 1'b1;
    compareOn = 1;

    // R2 R3 R4: strobes 1..3 clean, four repetitions
    goodMask = 5'b01110;
    calibrate(4, cyc, 0);
    chk("R3 lock latency reps=4", cyc, 41);
    chk("R4 centre of 1..3", int'(selPhase), 2);

    // R8 retimed stream from strobe 2
    for (int k = 0; k < 16; k++) begin
      prevBit = phaseSamples[2];
      @(negedge clk);
      chk("R8 retimed equals previous strobe sample", int'(retimedBit), int'(prevBit));
    end

    // R5 noise after lock
    goodMask = 5'b00000;
    repeat (40) @(negedge clk);
    chk("R5 locked held under noise", int'(locked), 1);
    chk("R5 selection held under noise", int'(selPhase), 2);

    // R4 top-edge even run, single repetition
    goodMask = 5'b11000;
    calibrate(1, cyc, 0);
    chk("R2 lock latency reps=1", cyc, 17);
    chk("R4 centre of 3..4", int'(selPhase), 3);

    // R2 zero repetitions behaves as one
    goodMask = 5'b11111;
    calibrate(0, cyc, 0);
    chk("R2 lock latency reps=0", cyc, 17);
    chk("R4 centre of all", int'(selPhase), 2);

    // R4 tied runs pick lower
    goodMask = 5'b11011;
    calibrate(2, cyc, 0);
    chk("R2 lock latency reps=2", cyc, 25);
    chk("R4 tie picks lower run", int'(selPhase), 0);

    // R9 one-sample glitch on strobe 4
    goodMask = 5'b11111;
    calibrate(4, cyc, 1);
    chk("R9 others unaffected by glitch", cyc, 41);
    chk("R9 glitched strobe dropped from run", int'(selPhase), 1);

    // R7 timeout
    goodMask = 5'b00000;
    timeoutPeriods = 8'd6;
    calibrate(4, cyc, 0);
    chk("R7 error latency", cyc, 48);
    chk("R7 error raised", int'(calError), 1);
    chk("R7 locked stays low", int'(locked), 0);
    goodMask = 5'b01110;
    repeat (60) @(negedge clk);
    chk("R7 search halted after error", int'(locked), 0);
    chk("R7 error held", int'(calError), 1);

    // R6 request clears error and relocks
    timeoutPeriods = 8'd200;
    calibrate(4, cyc, 0);
    chk("R6 relock after error", cyc, 41);
    chk("R6 locked after relock", int'(locked), 1);
    chk("R6 selection after relock", int'(selPhase), 2);

    repeat (10) @(negedge clk);
    compareOn = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule